// File: doc/BRIEF.md
# DMA Channel Count and Block Chaining Control

This block keeps the per-channel transfer parameters of a four-channel DMA engine: a start address, a remaining-transfer count and a transfer-type code. It also keeps one enable bit for each channel. A channel that has finished a transfer raises a one-cycle done pulse. The block then moves that channel's address forward and its count down, and raises the terminal-count output on the transfer that empties the count. Arbitration and bus strobe timing are left to the surrounding engine. The engine tells the block which channel currently holds the bus, and the block returns that channel's live address, count and type.

Two mode inputs change how a terminal count is handled. With the stop-on-count mode on, a channel that reaches terminal count loses its enable bit and stays idle until software sets the bit again. With chaining on, channels 2 and 3 work as a pair. A write to channel 2 also writes channel 3, so channel 3 holds the parameters of the next block. When channel 2 reaches terminal count, a reload cycle follows and copies channel 3 into channel 2, and channel 2 then carries on with no help from software. A status flag covers the reload so that the host knows when it must not rewrite channel 3. While chaining is on, channel 2 never loses its enable bit on terminal count. Channel 3 can still run transfers of its own, but every one of them changes what channel 2 will load next.

Top module: `dma_tc_ctrl`

## Requirements
- R1: In reset, and after it, every channel's address, count and type read as zero, all enable bits are 0, the update flag is 0 and the terminal-count output is 0.
- R2: A host write (wr_en=1) loads wr_addr, wr_cnt and wr_mode into the channel chosen by wr_ch at the next clock edge. With chaining off, no other channel changes.
- R3: A done pulse on a channel that is enabled and has a nonzero count adds one to the address and subtracts one from the count at the next edge. A done pulse on a disabled channel, or on a channel whose count is zero, changes nothing.
- R4: The terminal-count output is high, in the same cycle and with no register delay, whenever a done pulse hits an enabled channel whose count is exactly 1. After that transfer the count reads 0.
- R5: With stop-on-count on, a channel that hits terminal count reads enable 0 after the edge. If en_wr is high in that same cycle, the software value wins.
- R6: With stop-on-count off, a terminal count leaves every enable bit unchanged. Enable bits change only through en_wr, which loads all of them from en_wdata.
- R7: With chaining on, a host write to channel 2 writes the same address, count and type into channel 3.
- R8: With chaining on, a terminal count on channel 2 starts a reload cycle in the next clock cycle. At the end of that cycle, channel 2 takes channel 3's parameters as they stood during that cycle. This copy takes priority over a host write to channel 2 in that cycle, and over any channel 3 transfer in the same cycle.
- R9: The update flag goes high for the reload cycle and for one further cycle, then goes low again.
- R10: With chaining on, a terminal count on channel 2 never clears channel 2's enable bit, even when stop-on-count is on.
- R11: With chaining on, channel 3 still runs transfers when enabled, and each of them changes the values that channel 2 will later load.
- R12: cur_addr, cur_cnt and cur_mode show the parameters of the channel named by grant_ch, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host parameter write strobe |
| wr_ch | input | 2 | Channel chosen by the write |
| wr_addr | input | 16 | Start address to load |
| wr_cnt | input | 14 | Transfer count to load |
| wr_mode | input | 2 | Transfer-type code to load |
| en_wr | input | 1 | Load all enable bits |
| en_wdata | input | 4 | Enable bit values, bit n for channel n |
| xfer_done | input | 4 | One-cycle transfer-done pulse, bit n for channel n |
| grant_ch | input | 2 | Channel whose parameters are shown |
| tc_stop | input | 1 | Stop-on-count mode |
| autoload | input | 1 | Channel 2/3 chaining mode |
| cur_addr | output | 16 | Address of the granted channel |
| cur_cnt | output | 14 | Remaining count of the granted channel |
| cur_mode | output | 2 | Transfer type of the granted channel |
| tc | output | 1 | Terminal count of the current transfer |
| chan_en | output | 4 | Channel enable bits |
| upd_flag | output | 1 | Chaining reload in progress |

## Verification
The difficult cycle is the reload edge, because at that edge the copy into channel 2 can meet a channel 3 transfer and a host write to channel 2. A directed sequence sets up exactly that case. It expects channel 2 to hold channel 3's value from before the step, and channel 3 to hold its value from after the step. The random phase then mixes writes, enable loads, done pulses and mode changes, and uses short counts so that terminal counts and reloads happen often. A bench model written from the requirements predicts every output in every cycle.

// File: rtl/dmatc_pkg.sv
package dmatc_pkg;
    parameter int NCH    = 4;
    parameter int ADDR_W = 16;
    parameter int CNT_W  = 14;
    parameter int MODE_W = 2;
    parameter int DST_CH = 2;   // channel reloaded when chaining
    parameter int SRC_CH = 3;   // channel holding the next block
    localparam int CH_W  = $clog2(NCH);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [MODE_W-1:0] mode;
    } chan_regs_t;

    typedef enum logic [1:0] {
        UPD_IDLE = 2'd0,
        UPD_LOAD = 2'd1,
        UPD_HOLD = 2'd2
    } upd_state_t;

    function automatic chan_regs_t advance(input chan_regs_t r);
        chan_regs_t n;
        n      = r;
        n.addr = r.addr + 1'b1;
        n.cnt  = r.cnt - 1'b1;
        return n;
    endfunction
endpackage

// File: rtl/dmatc_chan.sv
module dmatc_chan
    import dmatc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ld,
    input  chan_regs_t ld_val,
    input  logic       rl,
    input  chan_regs_t rl_val,
    input  logic       xfer,
    input  logic       en,
    output chan_regs_t q,
    output logic       hit
);
    logic step;

    assign step = xfer && en && (q.cnt != '0);
    assign hit  = step && (q.cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (rl)   q <= rl_val;
        else if (ld)   q <= ld_val;
        else if (step) q <= advance(q);
    end

    // R3: a counted transfer moves address up and count down
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (xfer && en && q.cnt != '0 && !ld && !rl) |=>
            (q.addr == ADDR_W'($past(q.addr) + 1'b1)) &&
            (q.cnt  == CNT_W'($past(q.cnt) - 1'b1)));

    // R3: a disabled or idle channel keeps its parameters
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        ((!xfer || !en) && !ld && !rl) |=> $stable(q));

    // R4: terminal count leaves an empty counter
    p_empty_r4: assert property (@(posedge clk) disable iff (rst)
        (hit && !ld && !rl) |=> (q.cnt == '0));
endmodule

// File: rtl/dmatc_reload.sv
module dmatc_reload
    import dmatc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic rl,
    output logic flag
);
    upd_state_t st;

    always_ff @(posedge clk) begin
        if (rst) st <= UPD_IDLE;
        else begin
            unique case (st)
                UPD_IDLE: if (trig) st <= UPD_LOAD;
                UPD_LOAD: st <= UPD_HOLD;
                UPD_HOLD: st <= UPD_IDLE;
                default:  st <= UPD_IDLE;
            endcase
        end
    end

    assign rl   = (st == UPD_LOAD);
    assign flag = (st != UPD_IDLE);

    // R9: the flag spans the reload cycle and one cycle more
    p_load_hold_r9: assert property (@(posedge clk) disable iff (rst)
        rl |=> (flag && !rl));
    p_flag_end_r9: assert property (@(posedge clk) disable iff (rst)
        (flag && !rl) |=> !flag);
    // R8: a trigger while idle starts the reload next cycle
    p_start_r8: assert property (@(posedge clk) disable iff (rst)
        (trig && !flag) |=> rl);
endmodule

// File: rtl/dmatc_enables.sv
module dmatc_enables
    import dmatc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           wr,
    input  logic [NCH-1:0] wdata,
    input  logic [NCH-1:0] hit,
    input  logic [NCH-1:0] exempt,
    input  logic           tc_stop,
    output logic [NCH-1:0] en
);
    for (genvar c = 0; c < NCH; c++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)                                    en[c] <= 1'b0;
            else if (wr)                                en[c] <= wdata[c];
            else if (hit[c] && tc_stop && !exempt[c])   en[c] <= 1'b0;
        end

        // R5: stop-on-count drops the channel
        p_stop_r5: assert property (@(posedge clk) disable iff (rst)
            (hit[c] && tc_stop && !exempt[c] && !wr) |=> !en[c]);
        // R6: with no software load and no stop, the bit holds
        p_keep_r6: assert property (@(posedge clk) disable iff (rst)
            (!wr && !(hit[c] && tc_stop)) |=> (en[c] == $past(en[c])));
    end
endmodule

// File: rtl/dma_tc_ctrl.sv
module dma_tc_ctrl
    import dmatc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_cnt,
    input  logic [MODE_W-1:0] wr_mode,
    input  logic              en_wr,
    input  logic [NCH-1:0]    en_wdata,
    input  logic [NCH-1:0]    xfer_done,
    input  logic [CH_W-1:0]   grant_ch,
    input  logic              tc_stop,
    input  logic              autoload,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic [MODE_W-1:0] cur_mode,
    output logic              tc,
    output logic [NCH-1:0]    chan_en,
    output logic              upd_flag
);
    chan_regs_t     regs [NCH];
    chan_regs_t     wval;
    logic [NCH-1:0] hit;
    logic [NCH-1:0] exempt;
    logic           rl;
    logic           mirror;

    assign wval   = '{addr: wr_addr, cnt: wr_cnt, mode: wr_mode};
    assign mirror = autoload && wr_en && (wr_ch == CH_W'(DST_CH));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic ld_c;
        logic rl_c;
        assign ld_c      = (wr_en && (wr_ch == CH_W'(c))) || ((c == SRC_CH) && mirror);
        assign rl_c      = (c == DST_CH) && rl;
        assign exempt[c] = (c == DST_CH) && autoload;

        dmatc_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .ld     (ld_c),
            .ld_val (wval),
            .rl     (rl_c),
            .rl_val (regs[SRC_CH]),
            .xfer   (xfer_done[c]),
            .en     (chan_en[c]),
            .q      (regs[c]),
            .hit    (hit[c])
        );
    end

    dmatc_reload u_reload (
        .clk  (clk),
        .rst  (rst),
        .trig (hit[DST_CH] && autoload),
        .rl   (rl),
        .flag (upd_flag)
    );

    dmatc_enables u_en (
        .clk     (clk),
        .rst     (rst),
        .wr      (en_wr),
        .wdata   (en_wdata),
        .hit     (hit),
        .exempt  (exempt),
        .tc_stop (tc_stop),
        .en      (chan_en)
    );

    assign tc       = |hit;
    assign cur_addr = regs[grant_ch].addr;
    assign cur_cnt  = regs[grant_ch].cnt;
    assign cur_mode = regs[grant_ch].mode;

    // R8: the reload copies the partner set as it stood in that cycle
    p_copy_r8: assert property (@(posedge clk) disable iff (rst)
        rl |=> (regs[DST_CH] == $past(regs[SRC_CH])));
    // R7: a chained write lands in both channels
    p_mirror_r7: assert property (@(posedge clk) disable iff (rst)
        (mirror && !rl) |=> (regs[SRC_CH] == regs[DST_CH]));
    // R10: chaining shields channel 2 from stop-on-count
    p_keep_dst_r10: assert property (@(posedge clk) disable iff (rst)
        (autoload && hit[DST_CH] && !en_wr) |=> chan_en[DST_CH]);
    // R4: terminal count comes only from an enabled channel
    p_tc_src_r4: assert property (@(posedge clk) disable iff (rst)
        tc |-> ((xfer_done & chan_en) != '0));
endmodule

// File: tb/test_dma_tc_ctrl.sv
`timescale 1ns/1ps
module test_dma_tc_ctrl;
    import dmatc_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en;
    logic [1:0]        wr_ch;
    logic [15:0]       wr_addr;
    logic [13:0]       wr_cnt;
    logic [1:0]        wr_mode;
    logic              en_wr;
    logic [3:0]        en_wdata;
    logic [3:0]        xfer_done;
    logic [1:0]        grant_ch;
    logic              tc_stop;
    logic              autoload;
    logic [15:0]       cur_addr;
    logic [13:0]       cur_cnt;
    logic [1:0]        cur_mode;
    logic              tc;
    logic [3:0]        chan_en;
    logic              upd_flag;

    dma_tc_ctrl i_dma_tc_ctrl (.*);

    always #10 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference model
    logic [15:0] m_addr [4];
    logic [13:0] m_cnt  [4];
    logic [1:0]  m_mode [4];
    logic [3:0]  m_en;
    int          m_st;   // 0 idle, 1 reload cycle, 2 hold cycle

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit m_hit(int c);
        return xfer_done[c] && m_en[c] && (m_cnt[c] == 14'd1);
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            m_addr[c] = '0; m_cnt[c] = '0; m_mode[c] = '0;
        end
        m_en = '0;
        m_st = 0;
    endtask

    task automatic compare_all();
        bit h;
        h = 0;
        for (int c = 0; c < 4; c++) h |= m_hit(c);
        chk("R12 cur_addr", cur_addr, m_addr[grant_ch]);
        chk("R12 cur_cnt",  cur_cnt,  m_cnt[grant_ch]);
        chk("R12 cur_mode", cur_mode, m_mode[grant_ch]);
        chk("R4 tc",        tc,       h);
        chk("R5/R6 chan_en", chan_en, m_en);
        chk("R9 upd_flag",  upd_flag, m_st != 0);
    endtask

    task automatic model_next();
        logic [15:0] na [4];
        logic [13:0] nc [4];
        logic [1:0]  nm [4];
        logic [3:0]  ne;
        bit          hs [4];
        for (int c = 0; c < 4; c++) begin
            bit ld, stp;
            hs[c] = m_hit(c);
            stp = xfer_done[c] && m_en[c] && (m_cnt[c] != 0);
            ld  = (wr_en && wr_ch == c) || (c == 3 && autoload && wr_en && wr_ch == 2);
            na[c] = m_addr[c]; nc[c] = m_cnt[c]; nm[c] = m_mode[c];
            if (c == 2 && m_st == 1) begin
                na[c] = m_addr[3]; nc[c] = m_cnt[3]; nm[c] = m_mode[3];
            end else if (ld) begin
                na[c] = wr_addr; nc[c] = wr_cnt; nm[c] = wr_mode;
            end else if (stp) begin
                na[c] = m_addr[c] + 16'd1; nc[c] = m_cnt[c] - 14'd1;
            end
        end
        ne = m_en;
        if (en_wr) ne = en_wdata;
        else for (int c = 0; c < 4; c++)
            if (hs[c] && tc_stop && !(c == 2 && autoload)) ne[c] = 1'b0;
        case (m_st)
            0: if (hs[2] && autoload) m_st = 1;
            1: m_st = 2;
            default: m_st = 0;
        endcase
        for (int c = 0; c < 4; c++) begin
            m_addr[c] = na[c]; m_cnt[c] = nc[c]; m_mode[c] = nm[c];
        end
        m_en = ne;
    endtask

    task automatic tick();
        #1;
        compare_all();
        model_next();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; en_wr = 0; xfer_done = '0;
    endtask

    task automatic do_write(int ch, int a, int n, int m);
        wr_en = 1; wr_ch = 2'(ch); wr_addr = 16'(a); wr_cnt = 14'(n); wr_mode = 2'(m);
        tick();
        idle();
    endtask

    task automatic look(int ch);
        grant_ch = 2'(ch);
        #1;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        idle();
        wr_ch = 0; wr_addr = 0; wr_cnt = 0; wr_mode = 0; en_wdata = 0;
        grant_ch = 0; tc_stop = 0; autoload = 0;
        rst = 1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        #1;
        chk("R1 en in reset", chan_en, 0);
        chk("R1 flag in reset", upd_flag, 0);
        rst = 0;
        @(negedge clk);
        model_reset();
        look(3);
        chk("R1 addr after reset", cur_addr, 0);
        chk("R1 cnt after reset", cur_cnt, 0);
        chk("R1 tc after reset", tc, 0);

        // R2: plain write, chaining off
        do_write(1, 'h100, 2, 1);
        look(1);
        chk("R2 addr", cur_addr, 'h100);
        chk("R2 cnt", cur_cnt, 2);
        chk("R2 mode", cur_mode, 1);
        look(2);
        chk("R2 other channel untouched", cur_addr, 0);

        // R3 / R4 / R5 on channel 1 with stop-on-count
        tc_stop = 1;
        en_wr = 1; en_wdata = 4'b0010; tick(); idle();
        xfer_done = 4'b0010; look(1);
        chk("R4 no tc at count 2", tc, 0);
        tick(); idle(); look(1);
        chk("R3 addr step", cur_addr, 'h101);
        chk("R3 cnt step", cur_cnt, 1);
        xfer_done = 4'b0010; #1;
        chk("R4 tc at count 1", tc, 1);
        tick(); idle(); look(1);
        chk("R4 count empty", cur_cnt, 0);
        chk("R5 enable dropped", chan_en[1], 0);
        xfer_done = 4'b0010; tick(); idle(); look(1);
        chk("R3 disabled channel ignored", cur_addr, 'h102);

        // R6: stop-on-count off keeps enable
        tc_stop = 0;
        do_write(0, 'h40, 1, 0);
        en_wr = 1; en_wdata = 4'b0001; tick(); idle();
        xfer_done = 4'b0001; #1;
        chk("R6 tc", tc, 1);
        tick(); idle(); #1;
        chk("R6 enable kept", chan_en[0], 1);

        // R7 / R8 / R9 / R10 / R11 chaining
        tc_stop = 1; autoload = 1;
        do_write(2, 'h200, 1, 2);
        look(3);
        chk("R7 mirrored addr", cur_addr, 'h200);
        chk("R7 mirrored mode", cur_mode, 2);
        do_write(3, 'h300, 3, 3);
        en_wr = 1; en_wdata = 4'b1100; tick(); idle();
        xfer_done = 4'b0100; tick(); idle(); #1;
        chk("R9 flag in reload cycle", upd_flag, 1);
        chk("R10 channel 2 still enabled", chan_en[2], 1);
        // collision: channel 3 steps and host writes channel 2 during reload
        xfer_done = 4'b1000;
        wr_en = 1; wr_ch = 2; wr_addr = 'h777; wr_cnt = 9; wr_mode = 0;
        tick(); idle(); look(2);
        chk("R8 reload addr", cur_addr, 'h300);
        chk("R8 reload cnt", cur_cnt, 3);
        chk("R9 flag hold cycle", upd_flag, 1);
        look(3);
        chk("R11 channel 3 mirror write won over step", cur_addr, 'h777);
        tick(); #1;
        chk("R9 flag cleared", upd_flag, 0);
        // R11: channel 3 transfers alter the next reload
        do_write(3, 'h500, 2, 1);
        do_write(2, 'h600, 1, 0);
        do_write(3, 'h510, 2, 1);
        xfer_done = 4'b1000; tick(); idle();
        xfer_done = 4'b0100; tick(); idle();
        tick(); look(2);
        chk("R11 reload sees stepped addr", cur_addr, 'h511);
        chk("R11 reload sees stepped cnt", cur_cnt, 1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            idle();
            r = $urandom % 100;
            if (r < 20) begin
                wr_en = 1; wr_ch = 2'($urandom); wr_addr = 16'($urandom);
                wr_cnt = 14'($urandom % 5); wr_mode = 2'($urandom);
            end
            if (($urandom % 100) < 10) begin
                en_wr = 1; en_wdata = 4'($urandom);
            end
            if (($urandom % 100) < 50) xfer_done = 4'(1 << ($urandom % 4));
            if (($urandom % 100) < 3) tc_stop = ~tc_stop;
            if (($urandom % 100) < 3) autoload = ~autoload;
            grant_ch = 2'($urandom);
            tick();
        end

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule